// File: doc/BRIEF.md
# Extended-Cycle Shift Register Bit Generator with Three-Bit Translator

The block produces a pseudo-random bit stream. A 16-bit shift register with XOR feedback has one extra term, which makes its cycle pass through the all-zero state. The register therefore visits all 65536 values before it repeats. Each enabled clock advances the register by three single steps. The three bits that leave the top of the register in those steps form one group, and a fixed translator turns the group into zero, one or two output bits.

The output is a two-lane word. Each lane has its own valid bit. Lane 0 carries the first extracted bit of a group, and lane 1 carries the second bit when the group yields two. A consumer collects the valid lanes, lane 0 first, and ignores any cycle with no valid lane. The register can be loaded with any 16-bit seed, including zero.

A small control decode picks one of four actions each clock. CTL_RESET loads the reset seed. CTL_SEED loads the seed port. CTL_STEP advances the register by one group. CTL_HOLD keeps the register unchanged. The priority is reset, then seed load, then enable, then hold. The translator classifies each group as YIELD_NONE, YIELD_ONE or YIELD_TWO.

Top module: `xlfsr_tri_extract`

## Requirements
- R1: A synchronous reset loads the register with RESET_SEED (default 16'h0001). Reset takes priority over seed load and enable, and both valid bits are 0 while reset is high.
- R2: One single step shifts the register left by one. The new bit 0 is s[15]^s[14]^s[12]^s[3]^(s[14:0]==0), and the bit that leaves is s[15]. An enabled cycle performs three single steps.
- R3: The all-zero state lies on the cycle: 16'h8000 steps to 16'h0000, and 16'h0000 steps to 16'h0001. The group sequence repeats after exactly 65536 enabled cycles.
- R4: The group taken in a cycle is s[15:13] of the state at the start of that cycle. s[15] is the first bit of the group.
- R5: Groups 000 and 111 yield no output: out_valid_o is 2'b00.
- R6: Groups 001, 010, 101 and 110 yield two bits, with out_valid_o = 2'b11. The bit pairs, written lane 0 then lane 1, are (0,0), (0,1), (1,0) and (1,1) in that order of groups.
- R7: Group 011 yields a single 0 and group 100 yields a single 1, both on lane 0, with out_valid_o = 2'b01.
- R8: A data bit in a lane that is not valid is 0. Lane 1 is never valid unless lane 0 is valid.
- R9: A seed presented with seed_we_i is the register value after the next clock. Any value, including zero, is accepted. Seed load has priority over enable, and both valid bits are 0 in the load cycle.
- R10: While step_en_i is low and no load or reset is active, the register holds its value and both valid bits are 0.
- R11: Over one full period of 65536 enabled cycles the block emits exactly 81920 valid bits, and 40960 of them are ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_en_i | input | 1 | Advance one group this cycle |
| seed_we_i | input | 1 | Load seed_i on the next clock |
| seed_i | input | 16 | Seed value |
| out_bits_o | output | 2 | Extracted bits; lane 0 holds the first bit |
| out_valid_o | output | 2 | Per-lane valid mask |

## Verification
The hardest condition to reach from the ports is the pass through the all-zero state. It also bounds the full-period balance and repeat checks, because a natural run reaches zero only once in 65536 cycles.

The bench reaches it two ways:
- It loads 16'h8000 and 16'h0000 directly as seeds.
- It runs one uninterrupted period from the reset seed against a step-by-step model built from the feedback equation.

Each of the eight group patterns is forced by a seed whose top three bits equal that pattern.

// File: rtl/xlfsr_pkg.sv
package xlfsr_pkg;

    localparam int unsigned GROUP_BITS = 3;
    localparam int unsigned LANES      = 2;

    typedef enum logic [1:0] {
        YIELD_NONE = 2'd0,
        YIELD_ONE  = 2'd1,
        YIELD_TWO  = 2'd2
    } yield_e;

    typedef enum logic [1:0] {
        CTL_HOLD  = 2'd0,
        CTL_STEP  = 2'd1,
        CTL_SEED  = 2'd2,
        CTL_RESET = 2'd3
    } ctl_e;

endpackage

// File: rtl/xlfsr_advance.sv
module xlfsr_advance #(
    parameter int unsigned    W        = 16,
    parameter logic [W-1:0]   TAP_MASK = 16'hD008,
    parameter int unsigned    STEPS    = 3
) (
    input  logic [W-1:0]     state_i,
    output logic [W-1:0]     state_o,
    output logic [STEPS-1:0] group_o
);

    logic [W-1:0] chain [0:STEPS];

    assign chain[0] = state_i;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        logic fb;
        // feedback plus the term that splices the all-zero state into the cycle
        assign fb = (^(chain[k] & TAP_MASK)) ^ (~|chain[k][W-2:0]);
        assign chain[k+1] = {chain[k][W-2:0], fb};
        // first bit out lands in the MSB of the group
        assign group_o[STEPS-1-k] = chain[k][W-1];
    end

    assign state_o = chain[STEPS];

endmodule

// File: rtl/xlfsr_group_map.sv
module xlfsr_group_map
    import xlfsr_pkg::*;
(
    input  logic [GROUP_BITS-1:0] group_i,
    output yield_e                yield_o,
    output logic [LANES-1:0]      bits_o
);

    always_comb begin
        unique case (group_i)
            3'b000: begin yield_o = YIELD_NONE; bits_o = 2'b00; end
            3'b111: begin yield_o = YIELD_NONE; bits_o = 2'b00; end
            3'b001: begin yield_o = YIELD_TWO;  bits_o = 2'b00; end
            3'b010: begin yield_o = YIELD_TWO;  bits_o = 2'b10; end
            3'b101: begin yield_o = YIELD_TWO;  bits_o = 2'b01; end
            3'b110: begin yield_o = YIELD_TWO;  bits_o = 2'b11; end
            3'b011: begin yield_o = YIELD_ONE;  bits_o = 2'b00; end
            3'b100: begin yield_o = YIELD_ONE;  bits_o = 2'b01; end
            default: begin yield_o = YIELD_NONE; bits_o = 2'b00; end
        endcase
    end

endmodule

// File: rtl/xlfsr_tri_extract.sv
module xlfsr_tri_extract
    import xlfsr_pkg::*;
#(
    parameter int unsigned  W          = 16,
    parameter logic [W-1:0] TAP_MASK   = 16'hD008,
    parameter logic [W-1:0] RESET_SEED = 16'h0001
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_en_i,
    input  logic         seed_we_i,
    input  logic [W-1:0] seed_i,
    output logic [1:0]   out_bits_o,
    output logic [1:0]   out_valid_o
);

    logic [W-1:0]          lfsr_q;
    logic [W-1:0]          lfsr_adv;
    logic [GROUP_BITS-1:0] group;
    yield_e                yield_kind;
    logic [LANES-1:0]      map_bits;
    ctl_e                  ctl;

    xlfsr_advance #(
        .W        (W),
        .TAP_MASK (TAP_MASK),
        .STEPS    (GROUP_BITS)
    ) u_adv (
        .state_i (lfsr_q),
        .state_o (lfsr_adv),
        .group_o (group)
    );

    xlfsr_group_map u_map (
        .group_i (group),
        .yield_o (yield_kind),
        .bits_o  (map_bits)
    );

    always_comb begin
        if (rst_i)          ctl = CTL_RESET;
        else if (seed_we_i) ctl = CTL_SEED;
        else if (step_en_i) ctl = CTL_STEP;
        else                ctl = CTL_HOLD;
    end

    always_ff @(posedge clk_i) begin
        unique case (ctl)
            CTL_RESET: lfsr_q <= RESET_SEED;
            CTL_SEED:  lfsr_q <= seed_i;
            CTL_STEP:  lfsr_q <= lfsr_adv;
            CTL_HOLD:  lfsr_q <= lfsr_q;
            default:   lfsr_q <= lfsr_q;
        endcase
    end

    always_comb begin
        out_bits_o  = 2'b00;
        out_valid_o = 2'b00;
        if (ctl == CTL_STEP) begin
            unique case (yield_kind)
                YIELD_ONE: begin
                    out_valid_o = 2'b01;
                    out_bits_o  = {1'b0, map_bits[0]};
                end
                YIELD_TWO: begin
                    out_valid_o = 2'b11;
                    out_bits_o  = map_bits;
                end
                default: begin
                    out_valid_o = 2'b00;
                    out_bits_o  = 2'b00;
                end
            endcase
        end
    end

endmodule

// File: rtl/xlfsr_tri_extract_chk.sv
module xlfsr_tri_extract_chk #(
    parameter int unsigned  W          = 16,
    parameter logic [W-1:0] RESET_SEED = 16'h0001
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         step_en_i,
    input logic         seed_we_i,
    input logic [W-1:0] seed_i,
    input logic [1:0]   out_bits_o,
    input logic [1:0]   out_valid_o,
    input logic [W-1:0] state_i
);

    AST_RESET_VALUE: assert property (@(posedge clk_i) disable iff (rst_i) $fell(rst_i) |-> state_i == RESET_SEED); // R1
    AST_LANE_ORDER: assert property (@(posedge clk_i) disable iff (rst_i) out_valid_o[1] |-> out_valid_o[0]); // R8
    AST_DATA_MASKED: assert property (@(posedge clk_i) disable iff (rst_i) ((out_bits_o & ~out_valid_o) == 2'b00)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i) !step_en_i |-> out_valid_o == 2'b00); // R10
    AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (rst_i) (!step_en_i && !seed_we_i) |=> $stable(state_i)); // R10
    AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (rst_i) seed_we_i |=> state_i == $past(seed_i)); // R9
    AST_SEED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i) seed_we_i |-> out_valid_o == 2'b00); // R9
    AST_ZERO_EXIT: assert property (@(posedge clk_i) disable iff (rst_i) (state_i == '0 && step_en_i && !seed_we_i) |=> state_i == W'(4)); // R3

endmodule

bind xlfsr_tri_extract xlfsr_tri_extract_chk #(
    .W          (W),
    .RESET_SEED (RESET_SEED)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .step_en_i   (step_en_i),
    .seed_we_i   (seed_we_i),
    .seed_i      (seed_i),
    .out_bits_o  (out_bits_o),
    .out_valid_o (out_valid_o),
    .state_i     (lfsr_q)
);

// File: tb/xlfsr_tri_extract_tb.sv
`timescale 1ns/1ps
module xlfsr_tri_extract_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        we;
    logic [15:0] seed;
    logic [1:0]  obits;
    logic [1:0]  ovalid;

    int checks   = 0;
    int failures = 0;
    logic [15:0] m;
    bit done = 0;

    always #4 clk = ~clk;

    xlfsr_tri_extract u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .step_en_i   (en),
        .seed_we_i   (we),
        .seed_i      (seed),
        .out_bits_o  (obits),
        .out_valid_o (ovalid)
    );

    // {seed, expected valid, expected bits}; top three seed bits select the group
    localparam logic [19:0] VEC [8] = '{
        {16'h0123, 2'b00, 2'b00},
        {16'h2ABC, 2'b11, 2'b00},
        {16'h4321, 2'b11, 2'b10},
        {16'h6F0F, 2'b01, 2'b00},
        {16'h8001, 2'b01, 2'b01},
        {16'hA5A5, 2'b11, 2'b01},
        {16'hC3C3, 2'b11, 2'b11},
        {16'hFFFF, 2'b00, 2'b00}
    };

    function automatic logic [15:0] one_step(logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[14] ^ s[12] ^ s[3] ^ (s[14:0] == 15'd0);
        return {s[14:0], fb};
    endfunction

    function automatic logic [15:0] adv(logic [15:0] s);
        return one_step(one_step(one_step(s)));
    endfunction

    function automatic logic [3:0] exp_out(logic [15:0] s);
        case (s[15:13])
            3'b001: return 4'b1100;
            3'b010: return 4'b1110;
            3'b101: return 4'b1101;
            3'b110: return 4'b1111;
            3'b011: return 4'b0100;
            3'b100: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic run_model(int n, string req);
        for (int i = 0; i < n; i++) begin
            en = 1'b1; we = 1'b0;
            #1 chk(req, {ovalid, obits}, exp_out(m));
            @(negedge clk);
            m = adv(m);
        end
    endtask

    task automatic load(logic [15:0] s);
        we = 1'b1; en = 1'b1; seed = s;
        #1 chk("R9 load cycle quiet", {ovalid, obits}, 4'b0000);
        @(negedge clk);
        we = 1'b0;
        m = s;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] first [32];
        int mism, total, ones;
        rst = 1'b1; en = 1'b1; we = 1'b0; seed = 16'h0;
        repeat (3) @(negedge clk);
        #1 chk("R1 quiet in reset", {ovalid, obits}, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        m = 16'h0001;
        run_model(20, "R1 R2 R4 sequence from reset seed");

        // table of group patterns
        for (int i = 0; i < 8; i++) begin
            load(VEC[i][19:4]);
            en = 1'b1;
            #1 chk("R5 R6 R7 R4 group map", {ovalid, obits}, VEC[i][3:0]);
            chk("R8 lane rules", {ovalid[1] & ~ovalid[0], obits & ~ovalid}, 4'b0000);
            @(negedge clk);
            m = adv(m);
            run_model(3, "R2 follow-on groups");
        end

        // enable low holds state
        load(16'hC3C3);
        en = 1'b0;
        #1 chk("R10 idle quiet", {ovalid, obits}, 4'b0000);
        repeat (5) @(negedge clk);
        en = 1'b1;
        #1 chk("R10 state held", {ovalid, obits}, 4'b1111);
        @(negedge clk);
        m = adv(m);
        run_model(4, "R10 resume");

        // through the zero state
        load(16'h8000);
        en = 1'b1;
        #1 chk("R3 group from 8000", {ovalid, obits}, 4'b0101);
        @(negedge clk);
        m = adv(m);
        chk("R3 model passes zero", {m == 16'h0002, 3'b000}, 4'b1000);
        run_model(10, "R3 after zero pass");

        load(16'h0000);
        run_model(8, "R9 zero seed");

        // reset wins over load
        rst = 1'b1; we = 1'b1; seed = 16'hABCD; en = 1'b1;
        #1 chk("R1 reset priority quiet", {ovalid, obits}, 4'b0000);
        @(negedge clk);
        rst = 1'b0; we = 1'b0;
        m = 16'h0001;
        run_model(10, "R1 reset over load");

        // full period
        load(16'h0001);
        mism = 0; total = 0; ones = 0;
        for (int i = 0; i < 65536; i++) begin
            en = 1'b1;
            #1;
            if ({ovalid, obits} !== exp_out(m)) mism++;
            if (i < 32) first[i] = {ovalid, obits};
            total += ovalid[0] + ovalid[1];
            ones  += (obits[0] & ovalid[0]) + (obits[1] & ovalid[1]);
            @(negedge clk);
            m = adv(m);
        end
        checks++;
        if (mism != 0) begin
            failures++;
            $display("FAIL R2 full period mismatches actual=%0d expected=0", mism);
        end
        checks++;
        if (total != 81920) begin
            failures++;
            $display("FAIL R11 valid bits actual=%0d expected=81920", total);
        end
        checks++;
        if (ones != 40960) begin
            failures++;
            $display("FAIL R11 ones actual=%0d expected=40960", ones);
        end
        mism = 0;
        for (int i = 0; i < 32; i++) begin
            en = 1'b1;
            #1;
            if ({ovalid, obits} !== first[i]) mism++;
            @(negedge clk);
        end
        checks++;
        if (mism != 0) begin
            failures++;
            $display("FAIL R3 period repeat actual=%0d expected=0", mism);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule